// File: doc/BRIEF.md
# CPU Status Flag Register

This block is the eight-bit status register of a small processor core. It keeps the global interrupt enable, a one-bit copy store and the arithmetic flags. The arithmetic flags are half carry, sign, overflow, negative, zero and carry. The sign flag is never stored on its own: it always follows the negative and overflow flags through an exclusive OR.

Software reads and writes the register through a memory-mapped I/O port at one address. The ALU updates the arithmetic flags through a per-flag write-enable mask, so that each operation changes only the flags it affects. The control strobes are:
- interrupt acceptance, which clears the enable;
- return-from-interrupt and set-enable, which set it;
- clear-enable, which clears it.

A bit-store strobe copies one selected bit of an operand into the copy bit. A combinational bit-load path returns the operand with the selected bit replaced by the copy bit. A registered interrupt-pending output ORs the masked requests of all sources and gates the result with the enable.

All pins are plain control and status signals. There is no valid/ready handshake and no back-pressure: every strobe takes effect at the next rising clock edge.

Top module: `cpu_status_reg`

## Requirements
- R1: After reset `sreg` is 8'h00 and `irq_pending` is 0.
- R2: `io_rdata` equals `sreg` when `io_addr` is 6'h3F and 8'h00 at any other address. This is combinational.
- R3: When `io_wr` is high and `io_addr` is 6'h3F, `io_wdata` bits 7, 6, 5, 3, 2, 1 and 0 are stored at the next edge. A write at any other address changes nothing.
- R4: `sreg[4]` always equals `sreg[2] ^ sreg[3]`, both after writes and after ALU updates. Written bit 4 is ignored.
- R5: `alu_we`/`alu_flags` bit order is {H, V, N, Z, C}, mapping to `sreg` bits 5, 3, 2, 1 and 0. A flag whose enable bit is 1 takes its `alu_flags` bit. A flag whose enable bit is 0 holds its value. Bits 7 and 6 are never touched by the ALU.
- R6: `irq_ack` clears bit 7 at the next edge. This overrides an I/O write, `reti` and `sei` in the same cycle.
- R7: `reti` or `sei` sets bit 7 and `cli` clears it. Priority, highest first: `irq_ack`, I/O write, `reti`/`sei`, `cli`.
- R8: `bst` loads `operand[bit_idx]` into bit 6. An I/O write in the same cycle wins.
- R9: `bld_result` equals `operand` with bit `bit_idx` replaced by `sreg[6]`. This is combinational.
- R10: `irq_pending` is registered. At each edge it takes the value (new bit 7) AND OR-over-sources(`irq_req & irq_mask`). It is therefore 0 in every cycle in which bit 7 is 0.
- R11: An I/O write and an ALU update in the same cycle leave the written values in the arithmetic flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | 6 | I/O address of the access |
| io_wr | input | 1 | I/O write strobe |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | I/O read data |
| alu_we | input | 5 | Flag write enables {H,V,N,Z,C} |
| alu_flags | input | 5 | Flag values {H,V,N,Z,C} |
| irq_ack | input | 1 | Interrupt accepted, clears enable |
| reti | input | 1 | Return from interrupt, sets enable |
| sei | input | 1 | Set enable |
| cli | input | 1 | Clear enable |
| bst | input | 1 | Store operand bit into copy bit |
| bit_idx | input | 3 | Selected operand bit |
| operand | input | 8 | Register operand |
| bld_result | output | 8 | Operand with selected bit replaced by copy bit |
| irq_req | input | NSRC | Per-source interrupt requests |
| irq_mask | input | NSRC | Per-source interrupt masks |
| irq_pending | output | 1 | Registered gated interrupt request |
| sreg | output | 8 | Status register value |

## Verification
The hardest situations to reach are the same-cycle collisions. In one, an interrupt acceptance meets an I/O write that sets the enable together with set-enable. In another, a bit store meets a write, or an ALU update meets a write. Random stimulus hits these only rarely. Directed cycles therefore raise the colliding strobes together on purpose. A long random run then mixes all strobes at a moderate rate, with half the accesses aimed at the register address. The bench's next-state function checks every cycle.

// File: rtl/sreg_pkg.sv
package sreg_pkg;
  localparam int DATA_W  = 8;
  localparam int IDX_W   = $clog2(DATA_W);
  localparam int BIT_C   = 0;
  localparam int BIT_Z   = 1;
  localparam int BIT_N   = 2;
  localparam int BIT_V   = 3;
  localparam int BIT_S   = 4;
  localparam int BIT_H   = 5;
  localparam int BIT_T   = 6;
  localparam int BIT_I   = 7;
  localparam int ARITH_N = 5;

  // ALU flag index -> status bit position ({H,V,N,Z,C} -> 5,3,2,1,0)
  function automatic int arith_pos(input int i);
    return (i == 4) ? BIT_H : i;
  endfunction

  typedef struct packed {
    logic irq_ack;
    logic reti;
    logic sei;
    logic cli;
  } ien_ctl_t;
endpackage

// File: rtl/sreg_io_decode.sv
module sreg_io_decode #(
  parameter int ADDR_W    = 6,
  parameter int DW        = 8,
  parameter logic [ADDR_W-1:0] SREG_ADDR = 6'h3F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_wr,
  input  logic [DW-1:0]     sreg_q,
  output logic              wr_hit,
  output logic [DW-1:0]     io_rdata
);
  logic sel;
  assign sel      = (io_addr == SREG_ADDR);
  assign wr_hit   = io_wr & sel;
  assign io_rdata = sel ? sreg_q : '0;

  // R2: reads away from the register address return zero
  assert_read_other_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (io_addr != SREG_ADDR) |-> (io_rdata == '0));
endmodule

// File: rtl/sreg_bit_copy.sv
module sreg_bit_copy #(
  parameter int DW    = 8,
  parameter int IW    = $clog2(DW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] operand,
  input  logic [IW-1:0] bit_idx,
  input  logic          t_bit,
  output logic          sel_bit,
  output logic [DW-1:0] bld_result
);
  genvar g;
  generate
    for (g = 0; g < DW; g++) begin : g_ld
      assign bld_result[g] = (bit_idx == IW'(g)) ? t_bit : operand[g];
    end
  endgenerate
  assign sel_bit = operand[bit_idx];

  // R9: only the selected bit may differ from the operand
  assert_bld_other_bits_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (((bld_result ^ operand) & ~(DW'(1) << bit_idx)) == '0));
  assert_bld_sel_bit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bld_result[bit_idx] == t_bit);
endmodule

// File: rtl/sreg_flag_core.sv
module sreg_flag_core
  import sreg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_hit,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ARITH_N-1:0] alu_we,
  input  logic [ARITH_N-1:0] alu_flags,
  input  ien_ctl_t          ctl,
  input  logic              bst,
  input  logic              bst_bit,
  output logic [DATA_W-1:0] sreg_q,
  output logic              i_next
);
  logic [DATA_W-1:0] nxt;

  genvar a;
  generate
    for (a = 0; a < ARITH_N; a++) begin : g_arith
      localparam int P = arith_pos(a);
      assign nxt[P] = wr_hit     ? wdata[P]     :
                      alu_we[a]  ? alu_flags[a] : sreg_q[P];
    end
  endgenerate

  // Sign is always rebuilt from the new N and V
  assign nxt[BIT_S] = nxt[BIT_N] ^ nxt[BIT_V];

  assign nxt[BIT_T] = wr_hit ? wdata[BIT_T] :
                      bst    ? bst_bit      : sreg_q[BIT_T];

  always_comb begin
    if (ctl.irq_ack)                nxt[BIT_I] = 1'b0;
    else if (wr_hit)                nxt[BIT_I] = wdata[BIT_I];
    else if (ctl.reti || ctl.sei)   nxt[BIT_I] = 1'b1;
    else if (ctl.cli)               nxt[BIT_I] = 1'b0;
    else                            nxt[BIT_I] = sreg_q[BIT_I];
  end

  assign i_next = nxt[BIT_I];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sreg_q <= '0;
    else        sreg_q <= nxt;
  end

  // R4: sign flag consistent, even after a write with a stray bit 4
  assert_sign_parity_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sreg_q[BIT_S] == (sreg_q[BIT_N] ^ sreg_q[BIT_V]));
  assert_write_sign_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && (wdata[BIT_S] != (wdata[BIT_N] ^ wdata[BIT_V])))
      |=> (sreg_q[BIT_S] == (sreg_q[BIT_N] ^ sreg_q[BIT_V])));
  // R6: acceptance clears the enable regardless of other strobes
  assert_ack_clears_i_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.irq_ack |=> !sreg_q[BIT_I]);
  // R7: set strobes take effect when not overridden
  assert_set_i_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((ctl.sei || ctl.reti) && !ctl.irq_ack && !wr_hit) |=> sreg_q[BIT_I]);
  // R8: bit store lands in T
  assert_bst_loads_t_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bst && !wr_hit) |=> (sreg_q[BIT_T] == $past(bst_bit)));
  // R5: with no writer active the arithmetic flags hold
  assert_flags_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_hit && (alu_we == '0)) |=> $stable(sreg_q[5:0]));
endmodule

// File: rtl/sreg_irq_gate.sv
module sreg_irq_gate #(
  parameter int NSRC = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            i_next,
  input  logic            i_now,
  input  logic [NSRC-1:0] irq_req,
  input  logic [NSRC-1:0] irq_mask,
  output logic            irq_pending
);
  logic [NSRC-1:0] masked;
  genvar s;
  generate
    for (s = 0; s < NSRC; s++) begin : g_src
      assign masked[s] = irq_req[s] & irq_mask[s];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_pending <= 1'b0;
    else        irq_pending <= i_next & (|masked);
  end

  // R10: nothing passes while the enable is clear
  assert_gate_closed_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !i_now |-> !irq_pending);
  assert_no_masked_src_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq_req & irq_mask) == '0) |=> !irq_pending);
endmodule

// File: rtl/cpu_status_reg.sv
module cpu_status_reg
  import sreg_pkg::*;
#(
  parameter int NSRC   = 4,
  parameter int ADDR_W = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  io_addr,
  input  logic               io_wr,
  input  logic [DATA_W-1:0]  io_wdata,
  output logic [DATA_W-1:0]  io_rdata,
  input  logic [ARITH_N-1:0] alu_we,
  input  logic [ARITH_N-1:0] alu_flags,
  input  logic               irq_ack,
  input  logic               reti,
  input  logic               sei,
  input  logic               cli,
  input  logic               bst,
  input  logic [IDX_W-1:0]   bit_idx,
  input  logic [DATA_W-1:0]  operand,
  output logic [DATA_W-1:0]  bld_result,
  input  logic [NSRC-1:0]    irq_req,
  input  logic [NSRC-1:0]    irq_mask,
  output logic               irq_pending,
  output logic [DATA_W-1:0]  sreg
);
  logic     wr_hit;
  logic     sel_bit;
  logic     i_next;
  ien_ctl_t ctl;

  assign ctl = '{irq_ack: irq_ack, reti: reti, sei: sei, cli: cli};

  sreg_io_decode #(.ADDR_W(ADDR_W), .DW(DATA_W), .SREG_ADDR(ADDR_W'(6'h3F))) u_dec (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr),
    .sreg_q(sreg), .wr_hit(wr_hit), .io_rdata(io_rdata));

  sreg_bit_copy #(.DW(DATA_W), .IW(IDX_W)) u_copy (
    .clk(clk), .rst_n(rst_n), .operand(operand), .bit_idx(bit_idx),
    .t_bit(sreg[BIT_T]), .sel_bit(sel_bit), .bld_result(bld_result));

  sreg_flag_core u_core (
    .clk(clk), .rst_n(rst_n), .wr_hit(wr_hit), .wdata(io_wdata),
    .alu_we(alu_we), .alu_flags(alu_flags), .ctl(ctl),
    .bst(bst), .bst_bit(sel_bit), .sreg_q(sreg), .i_next(i_next));

  sreg_irq_gate #(.NSRC(NSRC)) u_gate (
    .clk(clk), .rst_n(rst_n), .i_next(i_next), .i_now(sreg[BIT_I]),
    .irq_req(irq_req), .irq_mask(irq_mask), .irq_pending(irq_pending));

  // R11: write beats ALU on arithmetic flags
  assert_write_beats_alu_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> (sreg[BIT_C] == $past(io_wdata[BIT_C]) && sreg[BIT_H] == $past(io_wdata[BIT_H])));
endmodule

// File: tb/sim_cpu_status_reg.sv
module sim_cpu_status_reg;
  localparam int CLK_PERIOD = 10;
  localparam int NSRC = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [5:0] io_addr;
  logic io_wr;
  logic [7:0] io_wdata, io_rdata;
  logic [4:0] alu_we, alu_flags;
  logic irq_ack, reti, sei, cli, bst;
  logic [2:0] bit_idx;
  logic [7:0] operand, bld_result, sreg;
  logic [NSRC-1:0] irq_req, irq_mask;
  logic irq_pending;

  cpu_status_reg #(.NSRC(NSRC)) u0 (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_wdata(io_wdata),
    .io_rdata(io_rdata), .alu_we(alu_we), .alu_flags(alu_flags), .irq_ack(irq_ack),
    .reti(reti), .sei(sei), .cli(cli), .bst(bst), .bit_idx(bit_idx), .operand(operand),
    .bld_result(bld_result), .irq_req(irq_req), .irq_mask(irq_mask),
    .irq_pending(irq_pending), .sreg(sreg));

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0;
  logic [7:0] m_sreg = 8'h00;
  logic m_pend = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // next status value from the requirements (R3..R8, R11)
  function automatic logic [7:0] model_next(input logic [7:0] s);
    logic [7:0] n;
    logic hit;
    int pos [5] = '{0, 1, 2, 3, 5};
    hit = io_wr && (io_addr == 6'h3F);
    n = s;
    for (int i = 0; i < 5; i++)
      n[pos[i]] = hit ? io_wdata[pos[i]] : (alu_we[i] ? alu_flags[i] : s[pos[i]]);
    n[6] = hit ? io_wdata[6] : (bst ? operand[bit_idx] : s[6]);
    if (irq_ack) n[7] = 1'b0;
    else if (hit) n[7] = io_wdata[7];
    else if (reti || sei) n[7] = 1'b1;
    else if (cli) n[7] = 1'b0;
    n[4] = n[2] ^ n[3];
    return n;
  endfunction

  function automatic logic [7:0] model_bld(input logic [7:0] s);
    logic [7:0] o;
    o = operand;
    o[bit_idx] = s[6];
    return o;
  endfunction

  task automatic idle();
    io_addr = 6'h00; io_wr = 0; io_wdata = 0; alu_we = 0; alu_flags = 0;
    irq_ack = 0; reti = 0; sei = 0; cli = 0; bst = 0; bit_idx = 0; operand = 0;
    irq_req = 0; irq_mask = 0;
  endtask

  // inputs set at negedge; comb checks, one edge, registered checks
  task automatic step(input string tag);
    logic [7:0] nx;
    #1;
    chk("R2 io_rdata", {24'h0, io_rdata}, {24'h0, (io_addr == 6'h3F) ? m_sreg : 8'h00});
    chk("R9 bld_result", {24'h0, bld_result}, {24'h0, model_bld(m_sreg)});
    nx = model_next(m_sreg);
    @(posedge clk);
    m_sreg = nx;
    m_pend = nx[7] & (|(irq_req & irq_mask));
    @(negedge clk);
    chk(tag, {24'h0, sreg}, {24'h0, m_sreg});
    chk("R10 irq_pending", {31'h0, irq_pending}, {31'h0, m_pend});
    idle();
  endtask

  task automatic wr(input logic [7:0] d);
    io_addr = 6'h3F; io_wr = 1; io_wdata = d;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    idle();
    repeat (3) @(negedge clk);
    chk("R1 sreg reset", {24'h0, sreg}, 32'h0);
    chk("R1 pending reset", {31'h0, irq_pending}, 32'h0);
    rst_n = 1;
    @(negedge clk);

    wr(8'hFF); step("R3 write all");
    chk("R4 S from N^V", {24'h0, sreg}, 32'hEF);
    wr(8'h04); step("R4 S from N");
    chk("R4 S=1", {24'h0, sreg}, 32'h14);
    wr(8'h10); step("R4 stray bit4");
    chk("R4 S dropped", {24'h0, sreg}, 32'h00);
    io_addr = 6'h3E; io_wr = 1; io_wdata = 8'hFF; step("R3 other address");
    chk("R3 ignored", {24'h0, sreg}, 32'h00);

    alu_we = 5'h1F; alu_flags = 5'h1F; step("R5 alu all");
    chk("R5 arith set", {24'h0, sreg}, 32'h2F);
    alu_we = 5'h01; alu_flags = 5'h00; step("R5 alu carry only");
    chk("R5 carry clr", {24'h0, sreg}, 32'h2E);
    alu_we = 5'h08; alu_flags = 5'h00; step("R5 alu V only");
    chk("R5 V clr S set", {24'h0, sreg}, 32'h36);
    wr(8'h00); alu_we = 5'h1F; alu_flags = 5'h1F; step("R11 write vs alu");
    chk("R11 write wins", {24'h0, sreg}, 32'h00);

    sei = 1; step("R7 sei");
    chk("R7 I set", {24'h0, sreg}, 32'h80);
    cli = 1; step("R7 cli");
    chk("R7 I clr", {24'h0, sreg}, 32'h00);
    reti = 1; step("R7 reti");
    chk("R7 reti sets", {24'h0, sreg}, 32'h80);
    sei = 1; cli = 1; wr(8'h00); step("R7 write over sei");
    chk("R7 write wins", {24'h0, sreg}, 32'h00);
    irq_ack = 1; sei = 1; wr(8'h80); step("R6 ack over all");
    chk("R6 I cleared", {24'h0, sreg}, 32'h00);

    bst = 1; operand = 8'h20; bit_idx = 3'd5; step("R8 bst one");
    chk("R8 T set", {24'h0, sreg}, 32'h40);
    operand = 8'h00; bit_idx = 3'd3; #1;
    chk("R9 T into bit3", {24'h0, bld_result}, 32'h08);
    bst = 1; operand = 8'hEF; bit_idx = 3'd4; step("R8 bst zero");
    chk("R8 T clr", {24'h0, sreg}, 32'h00);
    operand = 8'hFF; bit_idx = 3'd7; #1;
    chk("R9 T into bit7", {24'h0, bld_result}, 32'h7F);
    bst = 1; operand = 8'hFF; bit_idx = 3'd0; wr(8'h00); step("R8 write beats bst");
    chk("R8 T stays", {24'h0, sreg}, 32'h00);

    sei = 1; irq_req = 4'b0001; irq_mask = 4'b0000; step("R10 masked off");
    chk("R10 no pend", {31'h0, irq_pending}, 32'h0);
    irq_req = 4'b0101; irq_mask = 4'b0100; step("R10 pass");
    chk("R10 pend", {31'h0, irq_pending}, 32'h1);
    cli = 1; irq_req = 4'b1111; irq_mask = 4'b1111; step("R10 gate closed");
    chk("R10 closed", {31'h0, irq_pending}, 32'h0);

    for (int k = 0; k < 3000; k++) begin
      io_addr = ($urandom % 2) ? 6'h3F : 6'($urandom);
      io_wr = ($urandom % 5) == 0;
      io_wdata = 8'($urandom);
      alu_we = 5'($urandom); alu_flags = 5'($urandom);
      irq_ack = ($urandom % 8) == 0; reti = ($urandom % 8) == 0;
      sei = ($urandom % 6) == 0; cli = ($urandom % 6) == 0;
      bst = ($urandom % 3) == 0; bit_idx = 3'($urandom); operand = 8'($urandom);
      irq_req = NSRC'($urandom); irq_mask = NSRC'($urandom);
      step("R3 R5 R6 R7 R8 random");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule